// File: doc/BRIEF.md
# Dual 4-Bit Bidirectional Port Controller

This block holds two small bidirectional ports for a compact controller core. The CPU's instruction decoder hands it one decoded operation strobe per cycle, a 4-bit data or mask operand, and a standby flag. The block returns read data and a single test-bit result. It drives output values and per-pin output enables toward the pad ring.

Port A has no direction register. Its direction follows the class of the last operation that touched it. A read or a bit test turns the whole port around to input. A write, bit set or bit clear turns the whole port to output. Port B has an explicit direction register that sets each pin on its own. Both ports keep their output latches across direction changes. Standby releases every driver and blanks all input data.

Top module: `gpio_pair_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output enable of both ports is 0. Both output latches and the port B direction register are 0.
- R2: A read, test-true or test-false on port A, issued outside standby, makes every port A pin an input (enable 0) from the next cycle on.
- R3: A write, bit set or bit clear on port A, issued outside standby, makes every port A pin an output (enable 1) from the next cycle on.
- R4: The port A enables are always either all 0 or all 1.
- R5: The port A latch keeps its value while port A is an input. The next output-class operation drives that value again, so a bit set with mask 0 re-enables the old value unchanged.
- R6: On either port, a write loads the operand into the latch, a bit set ORs the operand into it, and a bit clear clears the latch bits where the operand is 1. The pin output value always shows the latch.
- R7: The port B direction operation loads the operand into the direction register from the next cycle on, one bit per pin, where 1 means output. The port B enables equal that register outside standby.
- R8: A port A read returns the port A pin inputs on rdata in the same cycle. A port B read returns the pin input for input bits and the latch for output bits. rdata is 0 when no read is issued.
- R9: A test-true sets tbit when any port bit selected by the operand mask is 1. A test-false sets tbit when all selected bits are 0. Tests never change a latch, and tbit is 0 when no test is issued.
- R10: In standby, every output enable is 0 and port inputs are seen as 0. Reads therefore return 0, test-true gives 0 and test-false gives 1. No operation changes latches or directions, and the prior state returns when standby ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Standby flag |
| op_rd_a | input | 1 | Read port A |
| op_tt_a | input | 1 | Test port A bits for true |
| op_tf_a | input | 1 | Test port A bits for false |
| op_wr_a | input | 1 | Write port A latch |
| op_sb_a | input | 1 | Set port A latch bits |
| op_rb_a | input | 1 | Clear port A latch bits |
| op_rd_b | input | 1 | Read port B |
| op_tt_b | input | 1 | Test port B bits for true |
| op_tf_b | input | 1 | Test port B bits for false |
| op_wr_b | input | 1 | Write port B latch |
| op_sb_b | input | 1 | Set port B latch bits |
| op_rb_b | input | 1 | Clear port B latch bits |
| op_dir_b | input | 1 | Load port B direction register |
| wdata | input | W | Operand: data or bit mask |
| pin_a_i | input | W | Port A pin inputs |
| pin_b_i | input | W | Port B pin inputs |
| pin_a_o | output | W | Port A output values |
| pin_a_oe | output | W | Port A output enables |
| pin_b_o | output | W | Port B output values |
| pin_b_oe | output | W | Port B output enables |
| rdata | output | W | Read data |
| tbit | output | 1 | Bit-test result |

## Verification
The bench sweeps every latch value against every mask, and every port B direction pattern against every pin pattern. A wrong set or clear merge, or a read mux that ignores direction, would then show up on at least one value. It checks that port A's latch survives a round trip through input mode and comes back with a zero-mask set. A design that cleared the latch on turnaround would drive 0 there. Standby is entered with operations still strobing, to catch a block that kept updating state or still drove the pads. Tests are issued on ports whose latch differs from the pins, which exposes a test that samples the latch or one that disturbs it.

// File: rtl/gpio_pair_ctl.sv
module gpio_pair_ctl #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stby,
  input  logic         op_rd_a,
  input  logic         op_tt_a,
  input  logic         op_tf_a,
  input  logic         op_wr_a,
  input  logic         op_sb_a,
  input  logic         op_rb_a,
  input  logic         op_rd_b,
  input  logic         op_tt_b,
  input  logic         op_tf_b,
  input  logic         op_wr_b,
  input  logic         op_sb_b,
  input  logic         op_rb_b,
  input  logic         op_dir_b,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_a_i,
  input  logic [W-1:0] pin_b_i,
  output logic [W-1:0] pin_a_o,
  output logic [W-1:0] pin_a_oe,
  output logic [W-1:0] pin_b_o,
  output logic [W-1:0] pin_b_oe,
  output logic [W-1:0] rdata,
  output logic         tbit
);

  logic [W-1:0] a_lat, b_lat, b_dir;
  logic         a_drv;
  logic         live;
  logic [W-1:0] a_view, b_view;
  logic         a_hit, b_hit;

  assign live = ~stby;

  function automatic logic [W-1:0] merge(input logic [W-1:0] cur, input logic wr,
                                         input logic sb, input logic rb,
                                         input logic [W-1:0] d);
    if (wr)      return d;
    else if (sb) return cur | d;
    else if (rb) return cur & ~d;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lat <= '0;
      b_lat <= '0;
      b_dir <= '0;
      a_drv <= 1'b0;
    end else if (live) begin
      a_lat <= merge(a_lat, op_wr_a, op_sb_a, op_rb_a, wdata);
      b_lat <= merge(b_lat, op_wr_b, op_sb_b, op_rb_b, wdata);
      if (op_dir_b) b_dir <= wdata;
      if (op_wr_a | op_sb_a | op_rb_a)
        a_drv <= 1'b1;
      else if (op_rd_a | op_tt_a | op_tf_a)
        a_drv <= 1'b0;
    end
  end

  assign a_view = live ? pin_a_i : '0;
  assign b_view = live ? ((pin_b_i & ~b_dir) | (b_lat & b_dir)) : '0;
  assign a_hit  = |(a_view & wdata);
  assign b_hit  = |(b_view & wdata);

  assign rdata = op_rd_a ? a_view : (op_rd_b ? b_view : '0);
  assign tbit  = (op_tt_a & a_hit) | (op_tf_a & ~a_hit) |
                 (op_tt_b & b_hit) | (op_tf_b & ~b_hit);

  assign pin_a_o  = a_lat;
  assign pin_b_o  = b_lat;
  assign pin_a_oe = {W{a_drv & live}};
  assign pin_b_oe = live ? b_dir : '0;

endmodule

// File: rtl/gpio_pair_ctl_chk.sv
module gpio_pair_ctl_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stby,
  input logic         op_rd_a,
  input logic         op_tt_a,
  input logic         op_tf_a,
  input logic         op_wr_a,
  input logic         op_sb_a,
  input logic         op_rb_a,
  input logic         op_tt_b,
  input logic         op_tf_b,
  input logic         op_dir_b,
  input logic [W-1:0] wdata,
  input logic [W-1:0] pin_a_o,
  input logic [W-1:0] pin_a_oe,
  input logic [W-1:0] pin_b_o,
  input logic [W-1:0] pin_b_oe,
  input logic [W-1:0] rdata
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_a_oe == '0 && pin_b_oe == '0));

  assert_a_to_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && (op_rd_a || op_tt_a || op_tf_a) && !(op_wr_a || op_sb_a || op_rb_a))
    |=> (stby || pin_a_oe == '0));

  assert_a_to_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && (op_wr_a || op_sb_a || op_rb_a)) |=> (stby || pin_a_oe == '1));

  assert_a_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_a_oe == '0 || pin_a_oe == '1));

  assert_b_dir_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && op_dir_b) |=> (stby || pin_b_oe == $past(wdata)));

  assert_test_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_tt_a || op_tf_a || op_tt_b || op_tf_b) && !(op_wr_a || op_sb_a || op_rb_a)
    |=> $stable(pin_a_o));

  assert_stby_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> (pin_a_oe == '0 && pin_b_oe == '0 && rdata == '0));

  assert_stby_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> ($stable(pin_a_o) && $stable(pin_b_o)));

endmodule

bind gpio_pair_ctl gpio_pair_ctl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .stby(stby),
  .op_rd_a(op_rd_a), .op_tt_a(op_tt_a), .op_tf_a(op_tf_a),
  .op_wr_a(op_wr_a), .op_sb_a(op_sb_a), .op_rb_a(op_rb_a),
  .op_tt_b(op_tt_b), .op_tf_b(op_tf_b), .op_dir_b(op_dir_b),
  .wdata(wdata), .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe),
  .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe), .rdata(rdata)
);

// File: tb/gpio_pair_ctl_tb.sv
module gpio_pair_ctl_tb_top;
  localparam int W = 4;
  localparam int RD_A = 0, TT_A = 1, TF_A = 2, WR_A = 3, SB_A = 4, RB_A = 5,
                 RD_B = 6, TT_B = 7, TF_B = 8, WR_B = 9, SB_B = 10, RB_B = 11,
                 DIR_B = 12, NOP = 13;

  logic clk = 0, rst_n = 0, stby = 0;
  logic [12:0] s = '0;
  logic [W-1:0] wdata = '0, pin_a_i = '0, pin_b_i = '0;
  logic [W-1:0] pin_a_o, pin_a_oe, pin_b_o, pin_b_oe, rdata;
  logic tbit;

  int checks = 0, errors = 0;
  logic [W-1:0] m_alat = '0, m_blat = '0, m_bdir = '0;
  logic m_adrv = 0;

  always #4 clk = ~clk;

  gpio_pair_ctl #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stby(stby),
    .op_rd_a(s[RD_A]), .op_tt_a(s[TT_A]), .op_tf_a(s[TF_A]),
    .op_wr_a(s[WR_A]), .op_sb_a(s[SB_A]), .op_rb_a(s[RB_A]),
    .op_rd_b(s[RD_B]), .op_tt_b(s[TT_B]), .op_tf_b(s[TF_B]),
    .op_wr_b(s[WR_B]), .op_sb_b(s[SB_B]), .op_rb_b(s[RB_B]),
    .op_dir_b(s[DIR_B]), .wdata(wdata), .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
    .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o),
    .pin_b_oe(pin_b_oe), .rdata(rdata), .tbit(tbit)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " R4 a_oe"}, pin_a_oe, (m_adrv && !stby) ? '1 : '0);
    chk({tag, " R6 a_o"}, pin_a_o, m_alat);
    chk({tag, " R7 b_oe"}, pin_b_oe, stby ? '0 : m_bdir);
    chk({tag, " R6 b_o"}, pin_b_o, m_blat);
  endtask

  task automatic op(input int code, input logic [W-1:0] d, input string tag);
    logic [W-1:0] av, bv, er;
    logic et;
    @(negedge clk);
    s = '0;
    if (code != NOP) s[code] = 1'b1;
    wdata = d;
    #1;
    av = stby ? '0 : pin_a_i;
    bv = stby ? '0 : ((pin_b_i & ~m_bdir) | (m_blat & m_bdir));
    er = (code == RD_A) ? av : (code == RD_B) ? bv : '0;
    et = (code == TT_A) ? |(av & d) : (code == TF_A) ? ~|(av & d) :
         (code == TT_B) ? |(bv & d) : (code == TF_B) ? ~|(bv & d) : 1'b0;
    chk({tag, " R8 rdata"}, rdata, er);
    chk({tag, " R9 tbit"}, {{(W-1){1'b0}}, tbit}, {{(W-1){1'b0}}, et});
    if (!stby) begin
      case (code)
        RD_A, TT_A, TF_A: m_adrv = 0;
        WR_A: begin m_alat = d; m_adrv = 1; end
        SB_A: begin m_alat = m_alat | d; m_adrv = 1; end
        RB_A: begin m_alat = m_alat & ~d; m_adrv = 1; end
        WR_B: m_blat = d;
        SB_B: m_blat = m_blat | d;
        RB_B: m_blat = m_blat & ~d;
        DIR_B: m_bdir = d;
        default: ;
      endcase
    end
    @(negedge clk);
    s = '0;
    #1;
    chk_state(tag);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset a_oe", pin_a_oe, '0);
    chk("R1 reset b_oe", pin_b_oe, '0);
    chk("R1 reset a_o", pin_a_o, '0);
    chk("R1 reset b_o", pin_b_o, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", pin_a_oe | pin_b_oe, '0);

    for (int v = 0; v < 16; v++) begin
      for (int m = 0; m < 16; m++) begin
        op(WR_A, W'(v), "R3 R6 write a");
        op(SB_A, W'(m), "R6 set a");
        op(WR_A, W'(v), "R6 write a");
        op(RB_A, W'(m), "R6 clear a");
        pin_a_i = W'(v ^ m);
        op(TT_A, W'(m), "R2 R9 test-true a");
        op(TF_A, W'(m), "R2 R9 test-false a");
        op(WR_B, W'(v), "R6 write b");
        op(SB_B, W'(m), "R6 set b");
        op(RB_B, W'(m ^ v), "R6 clear b");
      end
    end

    op(WR_A, 4'h5, "R5 prime");
    for (int p = 0; p < 16; p++) begin
      pin_a_i = W'(p);
      op(RD_A, 4'h0, "R2 R5 R8 read a");
    end
    op(SB_A, 4'h0, "R5 redrive");
    chk("R5 redriven value", pin_a_o, 4'h5);

    for (int d = 0; d < 16; d++) begin
      op(DIR_B, W'(d), "R7 dir b");
      op(WR_B, W'(~d), "R6 b latch");
      for (int p = 0; p < 16; p++) begin
        pin_b_i = W'(p * 7);
        op(RD_B, 4'h0, "R8 read b");
        op(TT_B, W'(p), "R9 test-true b");
        op(TF_B, W'(p), "R9 test-false b");
      end
    end

    op(WR_A, 4'hA, "R10 setup a");
    op(DIR_B, 4'h6, "R10 setup b");
    op(WR_B, 4'h3, "R10 setup b latch");
    pin_a_i = 4'hF;
    pin_b_i = 4'hF;
    stby = 1;
    for (int c = 0; c <= NOP; c++) op(c, 4'hF, "R10 standby op");
    op(RD_A, 4'h0, "R10 standby read a");
    op(TF_B, 4'hF, "R10 standby test-false");
    stby = 0;
    op(NOP, 4'h0, "R10 resume");
    chk("R10 a latch kept", pin_a_o, 4'hA);
    chk("R10 a drives again", pin_a_oe, 4'hF);
    chk("R10 b dir kept", pin_b_oe, 4'h6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule